// File: doc/BRIEF.md
# Write Status Token Decoder

After a host has sent one data block to a memory card, the card answers on data line 0 with a short status token and then holds the line low while it programs the block. This block watches that line and decides the outcome of each written block. It reports the outcome as accepted, CRC error, write failure or timeout. When an accepted block's busy period ends, it gives a ready pulse so that a transfer sequencer may start the next block.

Each block begins with a start pulse. The block then collects a fixed window of line samples, taking one sample on each cycle that the bus clock enable is high. It searches that window for the token's start bit, which is the first low sample that directly follows a high sample. It then decodes the three status bits that follow. A card may begin its token anywhere in the window, and leading low samples left over from earlier bus activity are skipped. A bad outcome halts the block. No further start is taken until the sequencer begins a new transfer by raising the first-block flag with the start pulse. A programmable sample-count limit catches a card that never answers or never releases busy.

The bus clock enable must not be high in two consecutive clock cycles. The line value matters only in cycles where the enable is high. All pins are plain control and status signals. The block has no stream interface and applies no back-pressure.

Top module: `wstat_decoder`

## Requirements
- R1: After reset, res_valid, ready and aborted are all 0.
- R2: A start pulse is accepted when the block is idle. It is also accepted when the block is halted and first_blk is 1 in the same cycle, which clears aborted. A start in any other state is ignored: it neither restarts capture nor changes an outcome in progress.
- R3: After an accepted start, the next WIN (default 32) cycles with bit_en high each take one d0 sample into the window. Sample index 0 is the first sample taken. d0 is ignored in cycles where bit_en is low.
- R4: The start bit is the lowest window index i≥1 where sample i is 0 and sample i-1 is 1, so leading zeros are skipped. The status is samples i+1, i+2 and i+3, in that order, with sample i+1 as the most significant bit.
- R5: Status 010 gives res_code 0 (accepted), with aborted kept at 0. Every decoded result pulses res_valid for one cycle, on the second clock edge after the edge that took the last window sample.
- R6: Status 101 gives res_code 1 (card CRC error) and sets aborted.
- R7: Any status other than 010 and 101 gives res_code 2 (write failure) and sets aborted.
- R8: A window with no start bit, or with fewer than three status bits after the start bit, gives res_code 3 (timeout) and sets aborted.
- R9: After an accepted status, ready pulses for one cycle on the first high sample at index i+5 or later. That sample may be the newest window sample or any later sample. The end-bit sample at index i+4 never counts, even when it falls after the window.
- R10: tmo_limit counts the samples taken since the accepted start. If that count reaches tmo_limit before the window is full, or while the block waits for busy release, the block gives res_code 3, sets aborted, and gives no ready pulse for that block.
- R11: After a result with code 1, 2 or 3, ready stays 0 and aborted stays 1 until a start with first_blk = 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bus clock enable; d0 is sampled when high |
| d0 | input | 1 | Sampled value of data line 0 |
| start | input | 1 | Begin watching for one block's status |
| first_blk | input | 1 | With start: first block of a transfer, clears a halt |
| tmo_limit | input | TMO_W | Sample-count limit for token and busy release |
| res_valid | output | 1 | One-cycle pulse with a block outcome |
| res_code | output | 2 | 0 accepted, 1 CRC error, 2 write failure, 3 timeout |
| ready | output | 1 | One-cycle pulse: card released busy after an accepted block |
| aborted | output | 1 | Transfer halted after a bad outcome |

## Verification
The hardest case to reach is a token that starts at the very end of the window. In that case the end bit falls on the first sample after the window, and it must not be taken for a busy release. The stimulus reaches it by building each window from a chosen start-bit position, status, number of leading zeros and release index. Start positions 27, 28 and 29 then cover the end bit inside the window, the end bit after the window, and a status cut short. The busy timeout boundary is approached one sample at a time, so that the result is seen to stay quiet one sample before the limit.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_CRC   = 2'd1,
    RES_WFAIL = 2'd2,
    RES_TMO   = 2'd3
  } wstat_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_DECODE,
    ST_BUSY,
    ST_HALT
  } wstat_state_e;

  localparam logic [2:0] STAT_ACCEPT = 3'b010;
  localparam logic [2:0] STAT_CRCERR = 3'b101;
endpackage

// File: rtl/wstat_window.sv
module wstat_window #(
  parameter int WIN = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           shift_en,
  input  logic           bit_in,
  output logic [WIN-1:0] win_o,
  output logic           last_o
);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN - 1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o   <= '1;
      count_q <= '0;
    end else if (clear) begin
      win_o   <= '1;
      count_q <= '0;
    end else if (shift_en) begin
      win_o   <= {bit_in, win_o[WIN-1:1]};
      count_q <= count_q + 1'b1;
    end
  end

  assign last_o = (count_q == LAST_IDX);
endmodule

// File: rtl/wstat_locate.sv
module wstat_locate #(
  parameter int WIN = 32
) (
  input  logic [WIN-1:0] win_i,
  output logic           found_o,
  output logic           complete_o,
  output logic [2:0]     status_o,
  output logic           released_o,
  output logic           skip_end_o
);
  logic [WIN+5:0] ext;
  assign ext = {6'b0, win_i};

  always_comb begin
    found_o    = 1'b0;
    complete_o = 1'b0;
    status_o   = 3'b000;
    released_o = 1'b0;
    skip_end_o = 1'b0;
    for (int i = WIN - 1; i >= 1; i--) begin
      if (win_i[i-1] && !win_i[i]) begin
        found_o    = 1'b1;
        complete_o = (i + 3 <= WIN - 1);
        status_o   = {ext[i+1], ext[i+2], ext[i+3]};
        released_o = (WIN - 1 >= i + 5) && win_i[WIN-1];
        skip_end_o = (i == WIN - 4);
      end
    end
  end
endmodule

// File: rtl/wstat_timer.sv
module wstat_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q >= limit);
endmodule

// File: rtl/wstat_decoder.sv
module wstat_decoder
  import wstat_pkg::*;
#(
  parameter int WIN   = 32,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             d0,
  input  logic             start,
  input  logic             first_blk,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             res_valid,
  output logic [1:0]       res_code,
  output logic             ready,
  output logic             aborted
);
  wstat_state_e   state_q;
  logic           start_ok;
  logic           cap_shift;
  logic           win_last;
  logic [WIN-1:0] win;
  logic           found, complete, released, skip_end;
  logic [2:0]     status;
  logic           expired;
  logic           skip_q;
  wstat_res_e     res_q;

  assign start_ok  = start && ((state_q == ST_IDLE) ||
                               ((state_q == ST_HALT) && first_blk));
  assign cap_shift = (state_q == ST_CAPTURE) && bit_en;

  wstat_window #(.WIN(WIN)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .shift_en (cap_shift),
    .bit_in   (d0),
    .win_o    (win),
    .last_o   (win_last)
  );

  wstat_locate #(.WIN(WIN)) u_locate (
    .win_i      (win),
    .found_o    (found),
    .complete_o (complete),
    .status_o   (status),
    .released_o (released),
    .skip_end_o (skip_end)
  );

  wstat_timer #(.TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .tick      (bit_en && ((state_q == ST_CAPTURE) || (state_q == ST_BUSY))),
    .limit     (tmo_limit),
    .expired_o (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      res_valid <= 1'b0;
      res_q     <= RES_OK;
      ready     <= 1'b0;
      skip_q    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      ready     <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_HALT: begin
          if (start_ok) state_q <= ST_CAPTURE;
        end
        ST_CAPTURE: begin
          if (cap_shift && win_last) begin
            state_q <= ST_DECODE;
          end else if (expired) begin
            res_valid <= 1'b1;
            res_q     <= RES_TMO;
            state_q   <= ST_HALT;
          end
        end
        ST_DECODE: begin
          res_valid <= 1'b1;
          if (!found || !complete) begin
            res_q   <= RES_TMO;
            state_q <= ST_HALT;
          end else if (status == STAT_ACCEPT) begin
            res_q  <= RES_OK;
            skip_q <= skip_end;
            if (released) begin
              ready   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_BUSY;
            end
          end else if (status == STAT_CRCERR) begin
            res_q   <= RES_CRC;
            state_q <= ST_HALT;
          end else begin
            res_q   <= RES_WFAIL;
            state_q <= ST_HALT;
          end
        end
        ST_BUSY: begin
          if (bit_en && skip_q) begin
            skip_q <= 1'b0;
          end else if (bit_en && d0) begin
            ready   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (expired) begin
            res_valid <= 1'b1;
            res_q     <= RES_TMO;
            state_q   <= ST_HALT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_code = res_q;
  assign aborted  = (state_q == ST_HALT);
endmodule

// File: rtl/wstat_decoder_chk.sv
module wstat_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       first_blk,
  input logic       res_valid,
  input logic [1:0] res_code,
  input logic       ready,
  input logic       aborted
);
  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  p_ok_keeps_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd0) |-> !aborted);

  p_crc_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd1) |-> aborted);

  p_wfail_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd2) |-> aborted);

  p_tmo_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd3) |-> (aborted && !ready));

  p_halt_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (aborted && !(start && first_blk)) |=> aborted);

  p_halt_no_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> !ready);
endmodule

bind wstat_decoder wstat_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .first_blk (first_blk),
  .res_valid (res_valid),
  .res_code  (res_code),
  .ready     (ready),
  .aborted   (aborted)
);

// File: tb/tb_wstat_decoder.sv
`timescale 1ns/1ps
module tb_wstat_decoder;
  localparam int WIN   = 32;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, d0 = 1'b1, start = 1'b0, first_blk = 1'b0;
  logic [TMO_W-1:0] tmo_limit = 16'd1000;
  logic res_valid, ready, aborted;
  logic [1:0] res_code;

  int checks = 0, failures = 0;
  int n_res = 0, n_rdy = 0, last_code = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wstat_decoder #(.WIN(WIN), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .d0(d0), .start(start),
    .first_blk(first_blk), .tmo_limit(tmo_limit), .res_valid(res_valid),
    .res_code(res_code), .ready(ready), .aborted(aborted)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin n_res++; last_code = int'(res_code); end
      if (ready) n_rdy++;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_res = 0; n_rdy = 0; last_code = -1;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic do_start(bit first);
    @(posedge clk); #1 start = 1'b1; first_blk = first;
    @(posedge clk); #1 start = 1'b0; first_blk = 1'b0;
  endtask

  task automatic send_bit(bit b);
    @(posedge clk); #1 bit_en = 1'b1; d0 = b;
    @(posedge clk); #1 bit_en = 1'b0;
  endtask

  function automatic bit tok_bit(int i, int lead, int p, bit [2:0] st, int rel);
    if (i < lead) return 1'b0;
    if (i < p) return 1'b1;
    if (i == p) return 1'b0;
    if (i <= p + 3) return st[2 - (i - p - 1)];
    if (i == p + 4) return 1'b1;
    return (i >= rel);
  endfunction

  task automatic send_window(int lead, int p, bit [2:0] st, int rel);
    for (int i = 0; i < WIN; i++) send_bit(tok_bit(i, lead, p, st, rel));
  endtask

  task automatic t_reset();
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 ready", int'(ready), 0);
    check("R1 aborted", int'(aborted), 0);
  endtask

  task automatic t_accept_busy();
    clr(); do_start(1'b0);
    send_window(0, 3, 3'b010, 999); settle();
    check("R5 accepted result count", n_res, 1);
    check("R5 accepted code", last_code, 0);
    check("R5 not aborted", int'(aborted), 0);
    check("R9 no ready while busy in window", n_rdy, 0);
    for (int k = 0; k < 5; k++) send_bit(1'b0);
    settle();
    check("R9 no ready during busy", n_rdy, 0);
    do_start(1'b0);
    send_bit(1'b1); settle();
    check("R9 ready on release", n_rdy, 1);
    check("R2 start in busy ignored", n_res, 1);
  endtask

  task automatic t_release_in_window();
    clr(); do_start(1'b0);
    send_window(0, 5, 3'b010, 12); settle();
    check("R9 in-window release code", last_code, 0);
    check("R9 in-window release ready", n_rdy, 1);
  endtask

  task automatic t_leading_zeros();
    clr(); do_start(1'b0);
    send_window(2, 4, 3'b010, 10); settle();
    check("R4 leading zeros skipped code", last_code, 0);
    check("R4 leading zeros ready", n_rdy, 1);
  endtask

  task automatic t_crc();
    clr(); do_start(1'b0);
    send_window(0, 2, 3'b101, 9); settle();
    check("R6 crc code", last_code, 1);
    check("R6 crc aborted", int'(aborted), 1);
    check("R11 no ready after crc", n_rdy, 0);
  endtask

  task automatic t_halt_ignores_start();
    clr(); do_start(1'b0);
    send_window(0, 3, 3'b010, 10); settle();
    check("R2 halted start ignored", n_res, 0);
    check("R11 still aborted", int'(aborted), 1);
  endtask

  task automatic t_status(bit [2:0] st, int exp_code, string tag);
    clr(); do_start(1'b1);
    check({tag, " first clears abort"}, int'(aborted), 0);
    send_window(0, 6, st, 14); settle();
    check({tag, " code"}, last_code, exp_code);
    check({tag, " aborted"}, int'(aborted), 1);
    check({tag, " no ready"}, n_rdy, 0);
  endtask

  task automatic t_late_tokens();
    clr(); do_start(1'b1);
    for (int i = 0; i < WIN; i++) send_bit(1'b1);
    settle();
    check("R8 no start bit", last_code, 3);
    clr(); do_start(1'b1);
    send_window(0, 29, 3'b010, 999); settle();
    check("R8 short status", last_code, 3);
    clr(); do_start(1'b1);
    send_window(0, 28, 3'b010, 999); settle();
    check("R9 p28 accepted", last_code, 0);
    send_bit(1'b1); settle();
    check("R9 end bit after window not ready", n_rdy, 0);
    send_bit(1'b0); send_bit(1'b1); settle();
    check("R9 p28 ready", n_rdy, 1);
    clr(); do_start(1'b0);
    send_window(0, 27, 3'b010, 999); settle();
    check("R9 end bit in window not ready", n_rdy, 0);
    send_bit(1'b1); settle();
    check("R9 p27 ready", n_rdy, 1);
  endtask

  task automatic t_busy_timeout();
    clr(); tmo_limit = 16'd40; do_start(1'b0);
    send_window(0, 3, 3'b010, 999);
    for (int k = 0; k < 7; k++) send_bit(1'b0);
    settle();
    check("R10 no timeout before limit", n_res, 1);
    send_bit(1'b0); settle();
    check("R10 busy timeout count", n_res, 2);
    check("R10 busy timeout code", last_code, 3);
    send_bit(1'b1); settle();
    check("R10 no ready after timeout", n_rdy, 0);
  endtask

  task automatic t_token_timeout();
    clr(); tmo_limit = 16'd10; do_start(1'b1);
    for (int k = 0; k < 9; k++) send_bit(1'b1);
    settle();
    check("R10 token not yet timed out", n_res, 0);
    send_bit(1'b1); settle();
    check("R10 token timeout code", last_code, 3);
    check("R10 token timeout aborted", int'(aborted), 1);
    tmo_limit = 16'd1000;
  endtask

  task automatic t_gated_samples();
    clr(); do_start(1'b1);
    for (int i = 0; i < WIN; i++) begin
      @(posedge clk); #1 d0 = 1'b0;
      @(posedge clk); #1 bit_en = 1'b1; d0 = tok_bit(i, 0, 4, 3'b010, 11);
      @(posedge clk); #1 bit_en = 1'b0; d0 = 1'b0;
    end
    settle();
    check("R3 gated d0 ignored code", last_code, 0);
    check("R3 gated d0 ignored ready", n_rdy, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_accept_busy();
    t_release_in_window();
    t_leading_zeros();
    t_crc();
    t_halt_ignores_start();
    t_status(3'b110, 2, "R7 110");
    t_status(3'b111, 2, "R7 111");
    t_status(3'b000, 2, "R7 000");
    t_late_tokens();
    t_busy_timeout();
    t_token_timeout();
    t_gated_samples();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule